// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers up to 31 interrupt inputs, numbered 1 to 31, and drives one active-low request line to a processor core. Input 0 is kept for a separate fast interrupt path and takes no part here. Each input has a configuration register with three fields: an enable bit, an edge/level trigger mode and a 3-bit priority. Level 7 is the most urgent and level 0 the least. The request line falls as soon as any enabled source carries a condition that outranks the interrupt now in service. It does not wait for arbitration.

Software takes an interrupt by pulsing the vector-read strobe. On that clock edge the controller picks the winner from the sources pending at that moment, so a source that arrived after the request fell can still win. It returns the winner's source number on the vector output and pushes the winner's priority as the new current level. Software ends the handler with an end-of-interrupt strobe, which pops the level and restores the one below it. Nesting is tracked by a small state machine with three states. ST_IDLE means nothing is in service. ST_NESTED means one or more levels are active and there is room for more. ST_FULL means the level stack is full.

The state machine has these named transitions:
- ACK_FIRST: ST_IDLE to ST_NESTED.
- ACK_NEST: stays in ST_NESTED while the stack grows.
- REACH_FULL: ST_NESTED to ST_FULL.
- EOI_FROM_FULL: ST_FULL to ST_NESTED.
- EOI_POP: stays in ST_NESTED while the stack shrinks.
- EOI_LAST: ST_NESTED to ST_IDLE.
- ACK_EOI_SWAP: a read and an end-of-interrupt in the same cycle, which leaves the depth unchanged.

Top module: `pvic_top`

## Requirements
- R1: After reset, irq_n_o is 1, cur_active_o is 0, cur_level_o is 0 and vec_id_o is the spurious value 0. Every source is disabled and level-triggered, and no input is pending.
- R2: A level-triggered source (cfg_edge_i=0) is pending exactly while its input is high. If the input is set up before clock edge n, irq_n_o is still 1 after edge n+1 and is 0 after edge n+2. When the input drops, the request is withdrawn with the same delay.
- R3: An edge-triggered source (cfg_edge_i=1) becomes pending on a rising input. If the input rises before edge n, irq_n_o is still 1 after edge n+2 and is 0 after edge n+3. The source stays pending after the input falls, until it is acknowledged.
- R4: A source whose enable bit is 0 never pulls irq_n_o low and never wins a vector read.
- R5: A vector read returns the number of the qualifying source with the numerically highest priority. Priority 7 ranks highest and priority 0 lowest.
- R6: When several qualifying sources share the highest priority, the lowest source number wins.
- R7: A winning read shows the source number on vec_id_o after that edge. It sets cur_active_o to 1 and cur_level_o to the winner's priority. The read clears the pending state of an edge-triggered winner, but a level-triggered winner stays pending while its input is high.
- R8: While an interrupt is current, only enabled pending sources with a priority strictly above cur_level_o qualify, both for irq_n_o and for a vector read.
- R9: Each eoi_i pulse pops one level and restores the previous cur_level_o, or sets cur_active_o to 0 when no level is left. An eoi_i with nothing active has no effect.
- R10: A vector read with no qualifying source returns the spurious value 0 and leaves cur_active_o and cur_level_o unchanged.
- R11: Source 0 never takes part. Configuration writes that select index 0 are ignored, and input bit 0 never pulls irq_n_o low.
- R12: When vec_rd_i and eoi_i are high in the same cycle, the pop is applied first. Arbitration then runs against the restored level, and the winner is pushed in the same edge.
- R13: A configuration write to a source clears any latched edge-pending state of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Raw interrupt inputs, bit i is source i |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 5 | Source number being configured |
| cfg_en_i | input | 1 | Enable bit to write |
| cfg_edge_i | input | 1 | Trigger mode to write, 1 for edge and 0 for level |
| cfg_prio_i | input | 3 | Priority to write |
| vec_rd_i | input | 1 | Vector read and acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| vec_id_o | output | 5 | Source number from the last read, or 0 if spurious |
| irq_n_o | output | 1 | Active-low interrupt request |
| cur_active_o | output | 1 | 1 while an interrupt is in service |
| cur_level_o | output | 3 | Priority of the interrupt in service |

## Verification
Two operations can fall in the same clock cycle: the acknowledge of a new interrupt and the end-of-interrupt pop. The bench raises both strobes together while two levels are stacked and a source with the upper level is still pending. For a correct result, the popped level must let that source requalify, the vector must name it, the reported level must equal its priority, and a single later end-of-interrupt must fall back to the bottom level. That last check proves that exactly one entry was swapped. A second collision, a rising edge meeting its own acknowledge in the source cell, is resolved in favour of keeping the new edge pending.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int unsigned PRIO_W   = 3;
    localparam int unsigned PRIO_NUM = 1 << PRIO_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NESTED = 2'd1,
        ST_FULL   = 2'd2
    } nest_state_e;

    typedef struct packed {
        logic              en;
        logic              edge_mode;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

endpackage

// File: rtl/pvic_src_cell.sv
module pvic_src_cell
    import pvic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     raw_i,
    input  logic     cfg_we_i,
    input  src_cfg_t cfg_i,
    input  logic     ack_i,
    output src_cfg_t cfg_o,
    output logic     pend_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_pend_q;
    src_cfg_t               cfg_q;
    logic                   rise;

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q[0] <= raw_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // a fresh edge survives a same-cycle acknowledge or reconfiguration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_pend_q <= 1'b0;
        end else begin
            edge_pend_q <= (edge_pend_q & ~(ack_i | cfg_we_i)) | rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign pend_o = cfg_q.edge_mode ? edge_pend_q : sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
    import pvic_pkg::*;
#(
    parameter int unsigned SRC_N = 32,
    localparam int unsigned ID_W = $clog2(SRC_N)
) (
    input  logic [SRC_N-1:0]             req_i,
    input  logic [SRC_N-1:0][PRIO_W-1:0] prio_i,
    output logic                         any_o,
    output logic [ID_W-1:0]              win_id_o,
    output logic [PRIO_W-1:0]            win_prio_o
);

    // scan downward so that ties settle on the lowest index
    always_comb begin
        any_o      = 1'b0;
        win_id_o   = '0;
        win_prio_o = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req_i[i] && (!any_o || prio_i[i] >= win_prio_o)) begin
                any_o      = 1'b1;
                win_id_o   = ID_W'(i);
                win_prio_o = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack
    import pvic_pkg::*;
#(
    parameter int unsigned DEPTH = PRIO_NUM,
    localparam int unsigned SP_W  = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic              active_o,
    output logic [PRIO_W-1:0] level_o,
    output logic              below_active_o,
    output logic [PRIO_W-1:0] below_level_o,
    output logic              room_o,
    output logic              full_o,
    output logic [SP_W-1:0]   depth_o
);

    nest_state_e       state_q, state_nx;
    logic [SP_W-1:0]   sp_q, sp_after_pop, sp_next;
    logic [PRIO_W-1:0] stk_q [DEPTH];
    logic              pop_ok, push_ok;

    assign pop_ok       = pop_i && (state_q != ST_IDLE);
    assign sp_after_pop = sp_q - SP_W'(pop_ok);
    assign room_o       = sp_after_pop < SP_W'(DEPTH);
    assign push_ok      = push_i && room_o;
    assign sp_next      = sp_after_pop + SP_W'(push_ok);

    // transitions: ACK_FIRST, ACK_NEST, REACH_FULL, EOI_FROM_FULL,
    // EOI_POP, EOI_LAST, ACK_EOI_SWAP (depth unchanged)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sp_next == SP_W'(DEPTH))  state_nx = ST_FULL;
                else if (sp_next != '0)       state_nx = ST_NESTED;
            end
            ST_NESTED: begin
                if (sp_next == '0)                 state_nx = ST_IDLE;
                else if (sp_next == SP_W'(DEPTH))  state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (sp_next == '0)                 state_nx = ST_IDLE;
                else if (sp_next != SP_W'(DEPTH))  state_nx = ST_NESTED;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
        end else begin
            state_q <= state_nx;
            sp_q    <= sp_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else if (push_ok) begin
            stk_q[IDX_W'(sp_after_pop)] <= prio_i;
        end
    end

    always_comb begin
        active_o       = 1'b0;
        level_o        = '0;
        below_active_o = 1'b0;
        below_level_o  = '0;
        full_o         = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_NESTED, ST_FULL: begin
                active_o = 1'b1;
                level_o  = stk_q[IDX_W'(sp_q - 1'b1)];
                full_o   = (state_q == ST_FULL);
                if (sp_q > SP_W'(1)) begin
                    below_active_o = 1'b1;
                    below_level_o  = stk_q[IDX_W'(sp_q - SP_W'(2))];
                end
            end
            default: ;
        endcase
    end

    assign depth_o = sp_q;

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int unsigned SRC_N       = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned NEST_DEPTH  = PRIO_NUM,
    parameter int unsigned SPURIOUS_ID = 0,
    localparam int unsigned ID_W = $clog2(SRC_N),
    localparam int unsigned SP_W = $clog2(NEST_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  irq_src_i,
    input  logic              cfg_we_i,
    input  logic [ID_W-1:0]   cfg_sel_i,
    input  logic              cfg_en_i,
    input  logic              cfg_edge_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic              vec_rd_i,
    input  logic              eoi_i,
    output logic [ID_W-1:0]   vec_id_o,
    output logic              irq_n_o,
    output logic              cur_active_o,
    output logic [PRIO_W-1:0] cur_level_o
);

    logic [SRC_N-1:0]             pend, cfg_hit, ack_hit, req_now, req_rd;
    logic [SRC_N-1:0][PRIO_W-1:0] prio_v;
    src_cfg_t                     cfg_v [SRC_N];
    src_cfg_t                     cfg_wr;
    logic                         any_rd;
    logic [ID_W-1:0]              win_id;
    logic [PRIO_W-1:0]            win_prio;
    logic                         below_active, room, full;
    logic [PRIO_W-1:0]            below_level;
    logic                         chk_active;
    logic [PRIO_W-1:0]            chk_level;
    logic [SP_W-1:0]              stk_depth;

    assign cfg_wr = '{en: cfg_en_i, edge_mode: cfg_edge_i, prio: cfg_prio_i};

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign cfg_hit[g] = cfg_we_i && (cfg_sel_i == ID_W'(g)) && (g != 0);
        assign ack_hit[g] = vec_rd_i && any_rd && (win_id == ID_W'(g));
        assign prio_v[g]  = cfg_v[g].prio;

        pvic_src_cell #(.SYNC_STAGES(SYNC_STAGES)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (irq_src_i[g]),
            .cfg_we_i (cfg_hit[g]),
            .cfg_i    (cfg_wr),
            .ack_i    (ack_hit[g]),
            .cfg_o    (cfg_v[g]),
            .pend_o   (pend[g])
        );
    end

    // on a same-cycle end-of-interrupt the read sees the restored level
    assign chk_active = eoi_i ? below_active : cur_active_o;
    assign chk_level  = eoi_i ? below_level  : cur_level_o;

    always_comb begin
        for (int i = 0; i < SRC_N; i++) begin
            req_now[i] = (i != 0) && pend[i] && cfg_v[i].en && !full &&
                         (!cur_active_o || prio_v[i] > cur_level_o);
            req_rd[i]  = (i != 0) && pend[i] && cfg_v[i].en && room &&
                         (!chk_active || prio_v[i] > chk_level);
        end
    end

    pvic_arbiter #(.SRC_N(SRC_N)) arb_i (
        .req_i      (req_rd),
        .prio_i     (prio_v),
        .any_o      (any_rd),
        .win_id_o   (win_id),
        .win_prio_o (win_prio)
    );

    pvic_level_stack #(.DEPTH(NEST_DEPTH)) stk_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_i         (vec_rd_i && any_rd),
        .pop_i          (eoi_i),
        .prio_i         (win_prio),
        .active_o       (cur_active_o),
        .level_o        (cur_level_o),
        .below_active_o (below_active),
        .below_level_o  (below_level),
        .room_o         (room),
        .full_o         (full),
        .depth_o        (stk_depth)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n_o  <= 1'b1;
            vec_id_o <= ID_W'(SPURIOUS_ID);
        end else begin
            irq_n_o <= ~(|req_now);
            if (vec_rd_i) begin
                vec_id_o <= any_rd ? win_id : ID_W'(SPURIOUS_ID);
            end
        end
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
    import pvic_pkg::*;
#(
    parameter int unsigned ID_W        = 5,
    parameter int unsigned SP_W        = 4,
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned SPURIOUS_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vec_rd,
    input logic              eoi,
    input logic              any_rd,
    input logic [PRIO_W-1:0] win_prio,
    input logic [ID_W-1:0]   vec_id,
    input logic              active,
    input logic [PRIO_W-1:0] level,
    input logic [SP_W-1:0]   depth
);

    assert_ack_sets_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && any_rd) |=> (active && level == $past(win_prio)))
        else $error("ack did not load the winner level");

    assert_spurious_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !any_rd && !eoi) |=>
            (vec_id == ID_W'(SPURIOUS_ID) && $stable(level) && $stable(active)))
        else $error("spurious read disturbed state");

    assert_nest_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && any_rd && active && !eoi) |=> (level > $past(level)))
        else $error("nested ack did not raise the level");

    assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !vec_rd && depth == '0) |=> (depth == '0 && !active))
        else $error("eoi on empty stack changed state");

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= SP_W'(DEPTH))
        else $error("stack depth out of range");

endmodule

bind pvic_top pvic_checker #(
    .ID_W        (ID_W),
    .SP_W        (SP_W),
    .DEPTH       (NEST_DEPTH),
    .SPURIOUS_ID (SPURIOUS_ID)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_rd   (vec_rd_i),
    .eoi      (eoi_i),
    .any_rd   (any_rd),
    .win_prio (win_prio),
    .vec_id   (vec_id_o),
    .active   (cur_active_o),
    .level    (cur_level_o),
    .depth    (stk_depth)
);

// File: tb/pvic_top_tb.sv
module pvic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_edge = 1'b0;
    logic [2:0]  cfg_prio = '0;
    logic        vec_rd = 1'b0;
    logic        eoi = 1'b0;
    logic [4:0]  vec_id;
    logic        irq_n;
    logic        cur_active;
    logic [2:0]  cur_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pvic_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_src_i    (irq_src),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_en_i     (cfg_en),
        .cfg_edge_i   (cfg_edge),
        .cfg_prio_i   (cfg_prio),
        .vec_rd_i     (vec_rd),
        .eoi_i        (eoi),
        .vec_id_o     (vec_id),
        .irq_n_o      (irq_n),
        .cur_active_o (cur_active),
        .cur_level_o  (cur_level)
    );

    // {input mask, expected vector}; sources are level, enabled, priority = number mod 8
    localparam logic [36:0] VEC_TBL [9] = '{
        {32'h0000_0008, 5'd3},
        {32'h0000_0024, 5'd5},
        {32'h0080_8080, 5'd7},
        {32'h0000_0600, 5'd10},
        {32'h0001_0100, 5'd8},
        {32'h8000_0040, 5'd31},
        {32'h0000_0000, 5'd0},
        {32'h0000_0001, 5'd0},
        {32'h4040_4000, 5'd14}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input int idx, input bit en, input bit edg, input int pr);
        cfg_we = 1'b1; cfg_sel = 5'(idx); cfg_en = en; cfg_edge = edg; cfg_prio = 3'(pr);
        wait_cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_read();
        vec_rd = 1'b1;
        wait_cyc(1);
        vec_rd = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        wait_cyc(1);
        eoi = 1'b0;
    endtask

    task automatic do_both();
        vec_rd = 1'b1; eoi = 1'b1;
        wait_cyc(1);
        vec_rd = 1'b0; eoi = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 active", cur_active, 0);
        chk("R1 level", cur_level, 0);
        chk("R1 vec", vec_id, 0);

        for (int i = 1; i < 32; i++) cfg(i, 1'b1, 1'b0, i % 8);

        // table walk: R2 latency, R5 priority, R6 ties, R7 ack, R9 eoi, R10/R11 spurious
        for (int t = 0; t < 9; t++) begin
            logic [31:0] mask;
            int          exp_id;
            bit          exp_req;
            mask    = VEC_TBL[t][36:5];
            exp_id  = int'(VEC_TBL[t][4:0]);
            exp_req = (mask & 32'hFFFF_FFFE) != 0;
            irq_src = mask;
            wait_cyc(2);
            chk("R2 irq_n before latency", irq_n, 1);
            wait_cyc(1);
            chk("R2 irq_n after latency", irq_n, exp_req ? 0 : 1);
            do_read();
            chk("R5 R6 R10 R11 vector", vec_id, exp_id);
            if (exp_id != 0) begin
                chk("R7 level", cur_level, exp_id % 8);
                chk("R7 active", cur_active, 1);
                do_eoi();
                chk("R9 active after eoi", cur_active, 0);
            end else begin
                chk("R10 active unchanged", cur_active, 0);
            end
            irq_src = '0;
            wait_cyc(3);
            chk("R2 request withdrawn", irq_n, 1);
        end

        // R3 edge latency and hold
        cfg(4, 1'b1, 1'b1, 4);
        irq_src[4] = 1'b1;
        wait_cyc(3);
        chk("R3 irq_n before latency", irq_n, 1);
        wait_cyc(1);
        chk("R3 irq_n after latency", irq_n, 0);
        irq_src[4] = 1'b0;
        wait_cyc(4);
        chk("R3 held after input drop", irq_n, 0);
        do_read();
        chk("R3 vector", vec_id, 4);
        do_eoi();
        wait_cyc(2);
        chk("R7 edge pending cleared", irq_n, 1);

        // R7 level winner stays pending
        irq_src[3] = 1'b1;
        wait_cyc(3);
        do_read();
        chk("R7 level vector", vec_id, 3);
        do_eoi();
        wait_cyc(2);
        chk("R7 level stays pending", irq_n, 0);
        irq_src[3] = 1'b0;
        wait_cyc(3);
        chk("R2 fall", irq_n, 1);

        // R4 enable masking
        cfg(5, 1'b0, 1'b0, 5);
        irq_src[5] = 1'b1; irq_src[2] = 1'b1;
        wait_cyc(3);
        chk("R4 enabled one requests", irq_n, 0);
        do_read();
        chk("R4 disabled never wins", vec_id, 2);
        do_eoi();
        irq_src[2] = 1'b0;
        wait_cyc(3);
        chk("R4 disabled no request", irq_n, 1);
        irq_src[5] = 1'b0;

        // R8 nesting, R10 spurious, R12 collision, R9 pops
        irq_src[9] = 1'b1;
        wait_cyc(3);
        do_read();
        chk("R7 nest base vector", vec_id, 9);
        chk("R7 nest base level", cur_level, 1);
        wait_cyc(2);
        chk("R8 same level no request", irq_n, 1);
        irq_src[11] = 1'b1;
        wait_cyc(3);
        chk("R8 higher level requests", irq_n, 0);
        do_read();
        chk("R8 nested vector", vec_id, 11);
        chk("R8 nested level", cur_level, 3);
        wait_cyc(2);
        chk("R8 nothing above 3", irq_n, 1);
        do_read();
        chk("R10 spurious vector", vec_id, 0);
        chk("R10 level kept", cur_level, 3);
        do_both();
        chk("R12 vector", vec_id, 11);
        chk("R12 level", cur_level, 3);
        do_eoi();
        chk("R12 one entry swapped", cur_level, 1);
        chk("R9 still active", cur_active, 1);
        do_eoi();
        chk("R9 empty", cur_active, 0);
        do_eoi();
        chk("R9 empty eoi ignored active", cur_active, 0);
        chk("R9 empty eoi ignored level", cur_level, 0);
        irq_src[9] = 1'b0; irq_src[11] = 1'b0;
        wait_cyc(3);

        // R13 config write clears edge pending
        cfg(20, 1'b1, 1'b1, 4);
        irq_src[20] = 1'b1;
        wait_cyc(1);
        irq_src[20] = 1'b0;
        wait_cyc(5);
        chk("R13 pending before write", irq_n, 0);
        cfg(20, 1'b1, 1'b1, 4);
        wait_cyc(2);
        chk("R13 cleared by write", irq_n, 1);

        // R11 source 0 excluded
        cfg(0, 1'b1, 1'b0, 7);
        irq_src[0] = 1'b1;
        wait_cyc(4);
        chk("R11 no request", irq_n, 1);
        do_read();
        chk("R11 vector", vec_id, 0);
        chk("R11 active", cur_active, 0);
        irq_src[0] = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

endmodule